// File: doc/BRIEF.md
# Byte-Wide Fetch-Execute Sequencer

This block is a very small 8-bit processor core. It fetches one opcode byte at a time from a byte-wide synchronous memory. A 16-bit program counter supplies the address, and the counter is advanced as soon as the byte is taken. The core then decodes the byte. If the instruction carries an immediate byte, the core makes a second read to fetch it. The core holds two data registers, A and B, and a running count of machine cycles. Every memory read occupies one machine cycle, and one machine cycle lasts four clocks.

Three opcodes are recognised: an idle instruction and two register loads from an immediate. Any other opcode stops the core for good. When that happens the core raises an error flag and holds the offending byte together with the address it came from. Only a reset restarts the core.

The block is intended as the sequencing skeleton of a larger core. Integration needs only a read strobe, an address and a read-data bus.

Top module: `fetch_exec_core`

## Requirements
- R1: While the synchronous active-low reset is held, the core sets PC to the RESET_PC parameter (default 0x0100) and clears A, B, the machine-cycle count, the error flag and the completion pulse.
- R2: Each machine cycle lasts four clocks. During the first clock of a machine cycle, mem_rd is high for exactly one clock with mem_addr equal to PC. Memory returns the byte on mem_rdata one clock later, and the core samples it on the last clock of the machine cycle.
- R3: Opcode 0x00 changes nothing except PC, which advances by 1. It costs one machine cycle (4 clocks, one read).
- R4: Opcode 0x3E loads the byte that follows it into A and leaves B unchanged. PC advances by 2, and the instruction costs two machine cycles (8 clocks, two reads).
- R5: Opcode 0x06 loads the byte that follows it into B and leaves A unchanged. PC advances by 2, and the instruction costs two machine cycles.
- R6: mcycle_count increases by exactly one for every completed memory read, including the read of an unrecognised opcode.
- R7: Any other opcode value sets err_flag, places the opcode on err_opcode, and places its fetch address on err_pc. PC is left one past that address. After that the core makes no further reads, pulses instr_done no more, and leaves PC, A and B unchanged until reset.
- R8: PC wraps from 0xFFFF to 0x0000 when it is incremented.
- R9: instr_done is a single-clock pulse, raised once per completed instruction in the same clock that its register and PC results first appear.
- R10: Instructions run back to back from consecutive addresses. From 0x0100 the program 0x3E, 0x42, 0x00 leaves A at 0x42, PC at 0x0103 and mcycle_count at 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Read address (current PC) |
| mem_rd | output | 1 | Read strobe, first clock of each machine cycle |
| mem_rdata | input | 8 | Read data, valid one clock after the strobe |
| reg_a | output | 8 | Register A |
| reg_b | output | 8 | Register B |
| pc | output | 16 | Program counter |
| mcycle_count | output | CNT_W | Completed machine cycles since reset |
| instr_done | output | 1 | One-clock pulse per completed instruction |
| err_flag | output | 1 | Core halted on an unrecognised opcode |
| err_opcode | output | 8 | Opcode that caused the halt |
| err_pc | output | 16 | Address the offending opcode was fetched from |

## Verification
The hardest case to reach from the ports is the program counter wrapping past 0xFFFF. Starting from the normal reset address, getting there takes tens of thousands of instructions. The bench therefore runs a second instance with RESET_PC set just below the top of the address space. That instance executes a load whose immediate sits at 0xFFFF and whose following opcode is fetched from 0x0000. The halted state is reached by placing an unrecognised byte after a valid instruction. The bench then watches the strobe, PC and registers for many further clocks.

// File: rtl/core_pkg.sv
// Shared definitions for the fetch-execute sequencer: bus widths, opcode
// values, sequencer states and the opcode decode function.
// Assumes a byte-wide opcode space and a 16-bit address space.
package core_pkg;

    localparam int OPC_W  = 8;
    localparam int ADDR_W = 16;
    localparam int NREGS  = 2;

    localparam logic [OPC_W-1:0] OPC_NOP = 8'h00;
    localparam logic [OPC_W-1:0] OPC_LDA = 8'h3E;
    localparam logic [OPC_W-1:0] OPC_LDB = 8'h06;

    typedef enum logic [1:0] {
        ST_FETCH   = 2'd0,
        ST_OPERAND = 2'd1,
        ST_HALT    = 2'd2
    } seq_state_t;

    typedef enum logic [0:0] {
        DST_A = 1'b0,
        DST_B = 1'b1
    } dest_t;

    typedef struct packed {
        logic  valid;
        logic  needs_imm;
        dest_t dest;
    } decode_t;

    // Map an opcode byte onto its decoded control fields.
    function automatic decode_t decode_opcode(input logic [OPC_W-1:0] op);
        decode_t d;
        d.valid     = 1'b0;
        d.needs_imm = 1'b0;
        d.dest      = DST_A;
        case (op)
            OPC_NOP: d.valid = 1'b1;
            OPC_LDA: begin
                d.valid     = 1'b1;
                d.needs_imm = 1'b1;
                d.dest      = DST_A;
            end
            OPC_LDB: begin
                d.valid     = 1'b1;
                d.needs_imm = 1'b1;
                d.dest      = DST_B;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mcycle_timer.sv
// Machine-cycle timer: divides the clock into machine cycles of TICKS
// clocks and counts completed machine cycles.
// Assumes run drops only on a last tick; while run is low, the tick
// position and the count are frozen.
module mcycle_timer #(
    parameter int TICKS = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic             first_tick,
    output logic             last_tick,
    output logic [CNT_W-1:0] mcycle_count
);
    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

    logic [TW-1:0] tick_q;

    assign first_tick = (tick_q == '0);
    assign last_tick  = (tick_q == LAST);

    // Advance the tick position inside the current machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_q <= '0;
        else if (run)
            tick_q <= last_tick ? '0 : tick_q + TW'(1);
    end

    // Count each machine cycle as it completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mcycle_count <= '0;
        else if (run && last_tick)
            mcycle_count <= mcycle_count + CNT_W'(1);
    end

endmodule

// File: rtl/pc_unit.sv
// Program counter: resets to RESET_PC and steps by one on request,
// wrapping naturally at the top of the address space.
// Assumes at most one increment per clock.
module pc_unit #(
    parameter logic [15:0] RESET_PC = 16'h0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inc,
    output logic [15:0] pc
);
    // Hold or advance the fetch pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= RESET_PC;
        else if (inc)
            pc <= pc + 16'd1;
    end

endmodule

// File: rtl/data_regs.sv
// Data register bank: NREGS byte registers, each loaded from a shared
// immediate bus under its own enable.
// Assumes the enables are one-hot or zero.
module data_regs #(
    parameter int NREGS = 2,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREGS-1:0]         load_en,
    input  logic [W-1:0]             imm,
    output logic [NREGS-1:0][W-1:0]  regs_q
);
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        // Load register i from the immediate bus when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (load_en[i])
                regs_q[i] <= imm;
        end
    end

endmodule

// File: rtl/seq_ctrl.sv
// Sequencer control: walks opcode fetch, optional operand fetch and halt.
// On each last tick it consumes the byte on the read bus, requests a PC
// step, steers register loads and records an unknown opcode.
// Assumes rdata is stable on the last tick of each machine cycle.
module seq_ctrl
    import core_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  last_tick,
    input  logic [OPC_W-1:0]      rdata,
    input  logic [ADDR_W-1:0]     pc,
    output logic                  run,
    output logic                  pc_inc,
    output logic [NREGS-1:0]      load_en,
    output logic [OPC_W-1:0]      imm,
    output logic                  instr_done,
    output logic                  err_flag,
    output logic [OPC_W-1:0]      err_opcode,
    output logic [ADDR_W-1:0]     err_pc
);
    seq_state_t state_q, state_d;
    dest_t      dest_q, dest_d;
    decode_t    dec;
    logic       done_d;
    logic       bad_op;

    assign run = (state_q != ST_HALT);
    assign imm = rdata;

    // Decode the current byte and choose the next step of the sequence.
    always_comb begin
        dec     = decode_opcode(rdata);
        state_d = state_q;
        dest_d  = dest_q;
        pc_inc  = 1'b0;
        load_en = '0;
        done_d  = 1'b0;
        bad_op  = 1'b0;
        if (last_tick) begin
            case (state_q)
                ST_FETCH: begin
                    pc_inc = 1'b1;
                    if (!dec.valid) begin
                        state_d = ST_HALT;
                        bad_op  = 1'b1;
                    end else if (dec.needs_imm) begin
                        state_d = ST_OPERAND;
                        dest_d  = dec.dest;
                    end else begin
                        done_d = 1'b1;
                    end
                end
                ST_OPERAND: begin
                    pc_inc                 = 1'b1;
                    load_en[int'(dest_q)]  = 1'b1;
                    done_d                 = 1'b1;
                    state_d                = ST_FETCH;
                end
                default: ;
            endcase
        end
    end

    // Register the sequencer state, the pending destination and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_FETCH;
            dest_q     <= DST_A;
            instr_done <= 1'b0;
        end else begin
            state_q    <= state_d;
            dest_q     <= dest_d;
            instr_done <= done_d;
        end
    end

    // Capture the offending opcode and its fetch address on a halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag   <= 1'b0;
            err_opcode <= '0;
            err_pc     <= '0;
        end else if (bad_op) begin
            err_flag   <= 1'b1;
            err_opcode <= rdata;
            err_pc     <= pc;
        end
    end

endmodule

// File: rtl/fetch_exec_core.sv
// Top of the fetch-execute sequencer. Joins the machine-cycle timer, the
// program counter, the control sequencer and the data registers, and
// drives the read-only memory port.
// Assumes a memory that returns the addressed byte one clock after mem_rd.
module fetch_exec_core
    import core_pkg::*;
#(
    parameter logic [15:0] RESET_PC          = 16'h0100,
    parameter int          TICKS_PER_MCYCLE  = 4,
    parameter int          CNT_W             = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [15:0]       mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        reg_a,
    output logic [7:0]        reg_b,
    output logic [15:0]       pc,
    output logic [CNT_W-1:0]  mcycle_count,
    output logic              instr_done,
    output logic              err_flag,
    output logic [7:0]        err_opcode,
    output logic [15:0]       err_pc
);
    logic                          run;
    logic                          first_tick;
    logic                          last_tick;
    logic                          pc_inc;
    logic [NREGS-1:0]              load_en;
    logic [OPC_W-1:0]              imm;
    logic [NREGS-1:0][OPC_W-1:0]   regs_q;

    mcycle_timer #(
        .TICKS (TICKS_PER_MCYCLE),
        .CNT_W (CNT_W)
    ) timer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .first_tick   (first_tick),
        .last_tick    (last_tick),
        .mcycle_count (mcycle_count)
    );

    pc_unit #(
        .RESET_PC (RESET_PC)
    ) pc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (pc_inc),
        .pc    (pc)
    );

    seq_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_tick  (last_tick),
        .rdata      (mem_rdata),
        .pc         (pc),
        .run        (run),
        .pc_inc     (pc_inc),
        .load_en    (load_en),
        .imm        (imm),
        .instr_done (instr_done),
        .err_flag   (err_flag),
        .err_opcode (err_opcode),
        .err_pc     (err_pc)
    );

    data_regs #(
        .NREGS (NREGS),
        .W     (OPC_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .imm     (imm),
        .regs_q  (regs_q)
    );

    assign mem_addr = pc;
    assign mem_rd   = run && first_tick;
    assign reg_a    = regs_q[int'(DST_A)];
    assign reg_b    = regs_q[int'(DST_B)];

endmodule

// File: rtl/fetch_exec_core_chk.sv
// Property checker for fetch_exec_core, attached by bind. Observes ports only.
module fetch_exec_core_chk #(
    parameter logic [15:0] RESET_PC = 16'h0100,
    parameter int          CNT_W    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_rd,
    input logic [7:0]       reg_a,
    input logic [7:0]       reg_b,
    input logic [15:0]      pc,
    input logic [CNT_W-1:0] mcycle_count,
    input logic             instr_done,
    input logic             err_flag
);
    AST_RESET_VALUES: assert property (@(posedge clk)
        !rst_n |=> (pc == RESET_PC && reg_a == 8'h00 && reg_b == 8'h00 &&
                    mcycle_count == '0 && !err_flag && !instr_done)); // R1

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R2

    AST_A_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_a != $past(reg_a)) |-> instr_done); // R4

    AST_B_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_b != $past(reg_b)) |-> instr_done); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mcycle_count != $past(mcycle_count)) |->
            (mcycle_count == $past(mcycle_count) + CNT_W'(1))); // R6

    AST_HALT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (!mem_rd && !instr_done)); // R7

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> (err_flag && $stable(pc) && $stable(reg_a) && $stable(reg_b))); // R7

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pc != $past(pc)) |-> (pc == $past(pc) + 16'd1)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done); // R9

endmodule

bind fetch_exec_core fetch_exec_core_chk #(
    .RESET_PC (RESET_PC),
    .CNT_W    (CNT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rd       (mem_rd),
    .reg_a        (reg_a),
    .reg_b        (reg_b),
    .pc           (pc),
    .mcycle_count (mcycle_count),
    .instr_done   (instr_done),
    .err_flag     (err_flag)
);

// File: tb/fetch_exec_core_tb_top.sv
// Directed bench for fetch_exec_core: one task per scenario, each checking
// its own results against values derived from the requirements.
module fetch_exec_core_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int n_checks = 0;
    int n_fails  = 0;

    // Main instance and its memory model
    logic [15:0] addr_m;
    logic        rd_m;
    logic [7:0]  rdata_m;
    logic [7:0]  a_m, b_m, eop_m;
    logic [15:0] pc_m, epc_m;
    logic [15:0] cnt_m;
    logic        done_m, err_m;
    logic [7:0]  mem_m [256];

    // Wrap instance, reset near the top of the address space
    logic [15:0] addr_w;
    logic        rd_w;
    logic [7:0]  rdata_w;
    logic [7:0]  a_w, b_w, eop_w;
    logic [15:0] pc_w, epc_w;
    logic [15:0] cnt_w;
    logic        done_w, err_w;
    logic [7:0]  mem_w [256];

    fetch_exec_core dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(addr_m), .mem_rd(rd_m),
        .mem_rdata(rdata_m), .reg_a(a_m), .reg_b(b_m), .pc(pc_m),
        .mcycle_count(cnt_m), .instr_done(done_m), .err_flag(err_m),
        .err_opcode(eop_m), .err_pc(epc_m)
    );

    fetch_exec_core #(.RESET_PC(16'hFFFE)) dut_w (
        .clk(clk), .rst_n(rst_n), .mem_addr(addr_w), .mem_rd(rd_w),
        .mem_rdata(rdata_w), .reg_a(a_w), .reg_b(b_w), .pc(pc_w),
        .mcycle_count(cnt_w), .instr_done(done_w), .err_flag(err_w),
        .err_opcode(eop_w), .err_pc(epc_w)
    );

    // One-clock-latency read-only memories
    always @(posedge clk) if (rd_m) rdata_m <= mem_m[addr_m[7:0]];
    always @(posedge clk) if (rd_w) rdata_w <= mem_w[addr_w[7:0]];

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            mem_m[i] = 8'h00;
            mem_w[i] = 8'h00;
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run until the chosen instance completes or halts; report clocks,
    // read strobes seen and the address of the first strobe.
    task automatic run_instr(input bit wrap, output int clks, output int rds,
                             output logic [15:0] first_addr, output bit halted);
        clks = 0; rds = 0; first_addr = 16'hxxxx; halted = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (wrap ? rd_w : rd_m) begin
                if (rds == 0) first_addr = wrap ? addr_w : addr_m;
                rds++;
            end
            @(negedge clk);
            clks++;
            if (wrap ? done_w : done_m) break;
            if (wrap ? err_w : err_m) begin
                halted = 1'b1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        clear_mem();
        apply_reset();
        chk("R1 pc", pc_m, 16'h0100);
        chk("R1 a", a_m, 8'h00);
        chk("R1 b", b_m, 8'h00);
        chk("R1 count", cnt_m, 0);
        chk("R1 err", err_m, 0);
        chk("R1 done", done_m, 0);
    endtask

    task automatic t_nop();
        int c, r; logic [15:0] fa; bit h;
        clear_mem();
        apply_reset();
        run_instr(1'b0, c, r, fa, h);
        chk("R3 clocks", c, 4);
        chk("R2 reads per nop", r, 1);
        chk("R2 read address", fa, 16'h0100);
        chk("R3 pc", pc_m, 16'h0101);
        chk("R3 a/b", {a_m, b_m}, 16'h0000);
        chk("R6 count", cnt_m, 1);
        @(negedge clk);
        chk("R9 pulse width", done_m, 0);
    endtask

    task automatic t_lda();
        int c, r; logic [15:0] fa; bit h;
        clear_mem();
        mem_m[8'h00] = 8'h3E; mem_m[8'h01] = 8'h5A;
        apply_reset();
        run_instr(1'b0, c, r, fa, h);
        chk("R4 clocks", c, 8);
        chk("R2 reads per load", r, 2);
        chk("R4 a", a_m, 8'h5A);
        chk("R4 b unchanged", b_m, 8'h00);
        chk("R4 pc", pc_m, 16'h0102);
        chk("R6 count", cnt_m, 2);
    endtask

    task automatic t_ldb();
        int c, r; logic [15:0] fa; bit h;
        clear_mem();
        mem_m[8'h00] = 8'h3E; mem_m[8'h01] = 8'h11;
        mem_m[8'h02] = 8'h06; mem_m[8'h03] = 8'hC3;
        apply_reset();
        run_instr(1'b0, c, r, fa, h);
        run_instr(1'b0, c, r, fa, h);
        chk("R5 clocks", c, 8);
        chk("R5 read address", fa, 16'h0102);
        chk("R5 b", b_m, 8'hC3);
        chk("R5 a unchanged", a_m, 8'h11);
        chk("R5 pc", pc_m, 16'h0104);
        chk("R6 count", cnt_m, 4);
    endtask

    task automatic t_sequence();
        int c, r; logic [15:0] fa; bit h;
        clear_mem();
        mem_m[8'h00] = 8'h3E; mem_m[8'h01] = 8'h42; mem_m[8'h02] = 8'h00;
        apply_reset();
        run_instr(1'b0, c, r, fa, h);
        chk("R10 a after load", a_m, 8'h42);
        run_instr(1'b0, c, r, fa, h);
        chk("R10 nop clocks", c, 4);
        chk("R10 a", a_m, 8'h42);
        chk("R10 pc", pc_m, 16'h0103);
        chk("R10 count", cnt_m, 3);
    endtask

    task automatic t_bad_opcode();
        int c, r, extra_rd, extra_done; logic [15:0] fa; bit h;
        clear_mem();
        mem_m[8'h00] = 8'h06; mem_m[8'h01] = 8'h99; mem_m[8'h02] = 8'hD3;
        apply_reset();
        run_instr(1'b0, c, r, fa, h);
        run_instr(1'b0, c, r, fa, h);
        chk("R7 halted", h, 1);
        chk("R7 clocks to halt", c, 4);
        chk("R7 err flag", err_m, 1);
        chk("R7 err opcode", eop_m, 8'hD3);
        chk("R7 err pc", epc_m, 16'h0102);
        chk("R7 pc", pc_m, 16'h0103);
        chk("R6 count incl bad fetch", cnt_m, 3);
        extra_rd = 0; extra_done = 0;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (rd_m) extra_rd++;
            if (done_m) extra_done++;
        end
        chk("R7 no reads after halt", extra_rd, 0);
        chk("R7 no done after halt", extra_done, 0);
        chk("R7 pc frozen", pc_m, 16'h0103);
        chk("R7 regs frozen", {a_m, b_m}, 16'h0099);
        chk("R7 count frozen", cnt_m, 3);
    endtask

    task automatic t_wrap();
        int c, r; logic [15:0] fa; bit h;
        clear_mem();
        mem_w[8'hFE] = 8'h3E; mem_w[8'hFF] = 8'h77; mem_w[8'h00] = 8'h00;
        apply_reset();
        run_instr(1'b1, c, r, fa, h);
        chk("R8 load across top a", a_w, 8'h77);
        chk("R8 pc wrapped", pc_w, 16'h0000);
        run_instr(1'b1, c, r, fa, h);
        chk("R8 fetch at zero", fa, 16'h0000);
        chk("R8 pc after wrap", pc_w, 16'h0001);
    endtask

    initial begin
        t_reset();
        t_nop();
        t_lda();
        t_ldb();
        t_sequence();
        t_bad_opcode();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule